// File: doc/BRIEF.md
# Colour-Tag Steering Switch

This block takes a stream of tagged messages, each a one-bit colour and a value, and delivers the value to one of two output streams. A message tagged red goes to the red stream. Any other tag sends it to the green stream. The tag is dropped on the way, so each output carries values only. Each stream uses a valid/ready handshake. A transfer takes place on a rising clock edge where valid and ready are both high.

Messages land in a small input queue first. A steering stage examines the message at the head of that queue. The head leaves the input queue only in the cycle in which it is written into the output queue its tag selects. If that output queue is full, the head stays where it is and nothing is lost. Every later message waits behind it, even one bound for the other output and even when that output has room. This head-of-line blocking is intended, and it keeps the order of arrival within each colour.

Each queue holds two entries by default and values are 8 bits wide. At most one message is steered per clock cycle.

Top module: `tagsplit_switch`

## Requirements
- R1: While and directly after the synchronous active-high reset, `red_valid` and `grn_valid` are low and `in_ready` is high.
- R2: A message with `in_tag` = 1 (red) appears only on the red output. A message with `in_tag` = 0 (green) appears only on the green output.
- R3: The output value equals the input value bit for bit. No tag bit is carried to either output.
- R4: When the input queue is empty, neither output queue is written.
- R5: The head message is removed from the input queue only in the same cycle that it is written into its selected output queue. A message accepted at a clock edge becomes visible on its output valid two edges later, provided the path is clear.
- R6: When the selected output queue is full, the head stays in place with its tag and value unchanged. No later message passes it, even if the other output is idle and ready.
- R7: At most one message is steered per clock cycle.
- R8: Values on each output keep their order of arrival. After the switch drains, the number of values delivered equals the number of messages accepted.
- R9: `in_ready` is low while the input queue is full, which is two messages by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input message present |
| in_ready | output | 1 | Input queue can accept a message |
| in_tag | input | 1 | Colour tag: 1 = red, 0 = green |
| in_value | input | VAL_W (8) | Message value |
| red_valid | output | 1 | Red output holds a value |
| red_ready | input | 1 | Red consumer accepts the value |
| red_value | output | VAL_W (8) | Red output value |
| grn_valid | output | 1 | Green output holds a value |
| grn_ready | input | 1 | Green consumer accepts the value |
| grn_value | output | VAL_W (8) | Green output value |

## Verification
The hardest state to reach is a blocked head whose colour queue is full while the other colour's consumer is idle and ready. Only in that state can a switch that drops or bypasses the head be told apart from a correct one. A directed sequence reaches it by stalling the red consumer, sending three red messages and then a green one, and confirming that the green output stays silent and the input closes. A sweep then runs every pairing of four backpressure levels on the two outputs with pseudo-random tags, so that blocking occurs often on each side. Every delivered value is matched against a reference queue for its colour.

// File: rtl/tagsplit_pkg.sv
package tagsplit_pkg;

  typedef enum logic {
    TAG_GREEN = 1'b0,
    TAG_RED   = 1'b1
  } tag_e;

endpackage

// File: rtl/tagsplit_fifo.sv
module tagsplit_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAPACITY = CW'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_idx;
  logic [AW-1:0]    rd_idx;
  logic [CW-1:0]    level;

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) store[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      level  <= '0;
    end else begin
      if (push) wr_idx <= advance(wr_idx);
      if (pop)  rd_idx <= advance(rd_idx);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rd_data = store[rd_idx];
  assign full    = (level == CAPACITY);
  assign empty   = (level == '0);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

  assert_level_grows_R8: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> !empty);

endmodule

// File: rtl/tagsplit_steer.sv
module tagsplit_steer
  import tagsplit_pkg::*;
(
  input  logic head_valid,
  input  tag_e head_tag,
  input  logic red_full,
  input  logic grn_full,
  output logic head_pop,
  output logic red_push,
  output logic grn_push
);

  logic want_red;
  logic want_grn;

  always_comb begin
    want_red = head_valid && (head_tag == TAG_RED);
    want_grn = head_valid && (head_tag != TAG_RED);
    // a blocked head is never removed; later messages wait behind it
    red_push = want_red && !red_full;
    grn_push = want_grn && !grn_full;
    head_pop = red_push || grn_push;
  end

endmodule

// File: rtl/tagsplit_switch.sv
module tagsplit_switch
  import tagsplit_pkg::*;
#(
  parameter int VAL_W     = 8,
  parameter int IN_DEPTH  = 2,
  parameter int OUT_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_tag,
  input  logic [VAL_W-1:0] in_value,
  output logic             red_valid,
  input  logic             red_ready,
  output logic [VAL_W-1:0] red_value,
  output logic             grn_valid,
  input  logic             grn_ready,
  output logic [VAL_W-1:0] grn_value
);

  localparam int MSG_W = VAL_W + 1;

  logic             in_full;
  logic             in_empty;
  logic [MSG_W-1:0] head_msg;
  logic             head_valid;
  tag_e             head_tag;
  logic [VAL_W-1:0] head_value;
  logic             head_pop;
  logic             red_push;
  logic             grn_push;
  logic             red_full;
  logic             red_empty;
  logic             grn_full;
  logic             grn_empty;

  assign in_ready = !in_full;

  tagsplit_fifo #(.WIDTH(MSG_W), .DEPTH(IN_DEPTH)) u_in_q (
    .clk     (clk),
    .rst     (rst),
    .push    (in_valid && !in_full),
    .wr_data ({in_tag, in_value}),
    .pop     (head_pop),
    .rd_data (head_msg),
    .full    (in_full),
    .empty   (in_empty)
  );

  assign head_valid = !in_empty;
  assign head_tag   = tag_e'(head_msg[MSG_W-1]);
  assign head_value = head_msg[VAL_W-1:0];

  tagsplit_steer u_steer (
    .head_valid (head_valid),
    .head_tag   (head_tag),
    .red_full   (red_full),
    .grn_full   (grn_full),
    .head_pop   (head_pop),
    .red_push   (red_push),
    .grn_push   (grn_push)
  );

  tagsplit_fifo #(.WIDTH(VAL_W), .DEPTH(OUT_DEPTH)) u_red_q (
    .clk     (clk),
    .rst     (rst),
    .push    (red_push),
    .wr_data (head_value),
    .pop     (red_valid && red_ready),
    .rd_data (red_value),
    .full    (red_full),
    .empty   (red_empty)
  );

  tagsplit_fifo #(.WIDTH(VAL_W), .DEPTH(OUT_DEPTH)) u_grn_q (
    .clk     (clk),
    .rst     (rst),
    .push    (grn_push),
    .wr_data (head_value),
    .pop     (grn_valid && grn_ready),
    .rd_data (grn_value),
    .full    (grn_full),
    .empty   (grn_empty)
  );

  assign red_valid = !red_empty;
  assign grn_valid = !grn_empty;

  assert_route_red_R2: assert property (@(posedge clk) disable iff (rst)
    red_push |-> (head_valid && head_tag == TAG_RED));

  assert_route_grn_R2: assert property (@(posedge clk) disable iff (rst)
    grn_push |-> (head_valid && head_tag == TAG_GREEN));

  assert_idle_when_empty_R4: assert property (@(posedge clk) disable iff (rst)
    in_empty |-> (!red_push && !grn_push));

  assert_enq_lands_R5: assert property (@(posedge clk) disable iff (rst)
    (red_push |=> red_valid) and (grn_push |=> grn_valid));

  assert_head_held_R6: assert property (@(posedge clk) disable iff (rst)
    (head_valid && !head_pop) |=>
      (head_valid && $stable(head_tag) && $stable(head_value)));

  assert_blocked_red_R6: assert property (@(posedge clk) disable iff (rst)
    (head_valid && head_tag == TAG_RED && red_full) |-> !head_pop);

  assert_one_move_R7: assert property (@(posedge clk) disable iff (rst)
    !(red_push && grn_push));

  assert_closed_when_full_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> !in_empty);

endmodule

// File: tb/tagsplit_switch_test.sv
`timescale 1ns/1ps
module tagsplit_switch_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_tag = 1'b0;
  logic [7:0] in_value = '0;
  logic       red_valid;
  logic       red_ready = 1'b0;
  logic [7:0] red_value;
  logic       grn_valid;
  logic       grn_ready = 1'b0;
  logic [7:0] grn_value;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int sent   = 0;
  int recvd  = 0;
  logic [7:0] ref_red [$];
  logic [7:0] ref_grn [$];
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  tagsplit_switch uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag), .in_value(in_value),
    .red_valid(red_valid), .red_ready(red_ready), .red_value(red_value),
    .grn_valid(grn_valid), .grn_ready(grn_ready), .grn_value(grn_value)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: got %0d cycles, expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Drive at a falling edge; account for transfers at the next rising edge.
  task automatic tick(input bit v, input bit t, input logic [7:0] d,
                      input bit rr, input bit gr, output bit acc);
    @(negedge clk);
    in_valid  = v;
    in_tag    = t;
    in_value  = d;
    red_ready = rr;
    grn_ready = gr;
    acc = v && in_ready;
    if (acc) begin
      sent = sent + 1;
      if (t) ref_red.push_back(d); else ref_grn.push_back(d);
    end
    if (red_valid && red_ready) begin
      recvd = recvd + 1;
      if (ref_red.size() == 0)
        check(1'b0, "R2", "spurious red value", red_value, 0);
      else begin
        logic [7:0] e;
        e = ref_red.pop_front();
        check(red_value == e, "R8", "red value order", red_value, e);
      end
    end
    if (grn_valid && grn_ready) begin
      recvd = recvd + 1;
      if (ref_grn.size() == 0)
        check(1'b0, "R2", "spurious green value", grn_value, 0);
      else begin
        logic [7:0] e;
        e = ref_grn.pop_front();
        check(grn_value == e, "R8", "green value order", grn_value, e);
      end
    end
  endtask

  task automatic drain();
    bit a;
    for (int k = 0; k < 60; k++) begin
      tick(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, a);
      if (ref_red.size() == 0 && ref_grn.size() == 0 && !red_valid && !grn_valid) break;
    end
    check(ref_red.size() == 0 && ref_grn.size() == 0, "R8", "drain complete",
          ref_red.size() + ref_grn.size(), 0);
  endtask

  task automatic send_until(input bit t, input logic [7:0] d, input bit rr, input bit gr);
    bit a;
    a = 1'b0;
    while (!a) tick(1'b1, t, d, rr, gr, a);
  endtask

  initial begin
    bit a;
    // reset
    repeat (3) @(posedge clk);
    #1;
    check(!red_valid && !grn_valid, "R1", "valids in reset", {red_valid, grn_valid}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!red_valid && !grn_valid, "R1", "valids after reset", {red_valid, grn_valid}, 0);
    check(in_ready, "R1", "in_ready after reset", in_ready, 1);

    // single red: latency and routing
    tick(1'b1, 1'b1, 8'hA5, 1'b0, 1'b0, a);
    tick(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, a);
    check(!red_valid && !grn_valid, "R5", "one edge after accept", red_valid, 0);
    tick(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, a);
    check(red_valid && red_value == 8'hA5, "R3", "red value", red_value, 8'hA5);
    check(!grn_valid, "R2", "red not on green", grn_valid, 0);
    drain();

    // single green
    tick(1'b1, 1'b0, 8'h3C, 1'b0, 1'b0, a);
    tick(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, a);
    tick(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, a);
    check(grn_valid && grn_value == 8'h3C, "R3", "green value", grn_value, 8'h3C);
    check(!red_valid, "R2", "green not on red", red_valid, 0);
    drain();

    // empty input: nothing appears
    repeat (4) tick(1'b0, 1'b1, 8'hFF, 1'b1, 1'b1, a);
    check(!red_valid && !grn_valid, "R4", "idle outputs", {red_valid, grn_valid}, 0);

    // head-of-line blocking: red stalled, green ready
    send_until(1'b1, 8'h11, 1'b0, 1'b1);
    send_until(1'b1, 8'h22, 1'b0, 1'b1);
    send_until(1'b1, 8'h33, 1'b0, 1'b1);
    send_until(1'b0, 8'h44, 1'b0, 1'b1);
    repeat (6) tick(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, a);
    check(!grn_valid, "R6", "green stays behind blocked red", grn_valid, 0);
    check(red_valid && red_value == 8'h11, "R6", "red head kept", red_value, 8'h11);
    check(!in_ready, "R9", "input closed when full", in_ready, 0);
    drain();

    // sweep of backpressure levels with random tags
    for (int lr = 0; lr < 4; lr++) begin
      for (int lg = 0; lg < 4; lg++) begin
        for (int m = 0; m < 120; m++) begin
          logic [31:0] r;
          bit t;
          logic [7:0] d;
          r = rnd();
          t = r[0];
          d = r[15:8];
          a = 1'b0;
          while (!a) begin
            bit rr;
            bit gr;
            rr = (rnd() % 4) >= lr;
            gr = (rnd() % 4) >= lg;
            tick(1'b1, t, d, rr, gr, a);
          end
        end
        drain();
      end
    end

    check(sent == recvd, "R8", "total out equals total in", recvd, sent);
    check(sent > 1900, "R7", "messages moved", sent, 1900);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule